// File: doc/BRIEF.md
# Edge-Order Indicator

This block watches two asynchronous level inputs, A and B. It reports on a 2-bit code which input went high last while the other input was already high. The code therefore records the order in which the two inputs arrived. When both inputs are low, the code returns to zero. A rise of B while A is held high sets code 01. A rise of A while B is held high sets code 10. Every other kind of change keeps the last code.

Each input passes through its own flop chain of configurable length before it is used. Edges are found by comparing each synchronised level with its value one clock earlier. Both inputs may rise within the same sample. In that case the order cannot be told, so the code holds.

Top module: `edge_order_ind`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `order_code` to 2'b00. The code stays 2'b00 for as long as `rst` is held.
- R2: Once both synchronised inputs are low, `order_code` becomes 2'b00. This holds whatever the previous code was.
- R3: When B rises while A is already high (A high in both the previous and the current sample), `order_code` becomes 2'b01. Bit 0 means "B arrived last".
- R4: When A rises while B is already high, `order_code` becomes 2'b10. Bit 1 means "A arrived last".
- R5: A falling edge never sets a code. If one input falls while the other stays high, the code holds. The value 2'b11 never appears.
- R6: If A and B rise in the same sample, the code holds its previous value.
- R7: A level change at an input reaches `order_code` exactly SYNC_STAGES+1 rising clock edges after it is first sampled.
- R8: A rise of one input while the other input is low leaves the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | Asynchronous level input A |
| in_b | input | 1 | Asynchronous level input B |
| order_code | output | 2 | Arrival-order code: 00 cleared, 01 B last, 10 A last |

## Verification
The bench builds two copies of the block side by side, one with the default two-stage synchroniser and one with three stages. Both copies see the same stimulus and must agree on every settled code. Driving them together makes the one-cycle difference in latency directly observable at the edge where each copy's output changes. The deeper copy also shows that the ordering and clearing behaviour does not depend on chain length.

// File: rtl/edge_order_ind.sv
module edge_order_ind #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_a,
  input  logic       in_b,
  output logic [1:0] order_code
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] a_chain, b_chain;
  logic a_now, b_now, a_was, b_was;
  logic a_rise, b_rise;
  logic [1:0] order_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_chain <= '0;
      b_chain <= '0;
      a_was   <= 1'b0;
      b_was   <= 1'b0;
    end else begin
      a_chain <= {a_chain[SYNC_STAGES-2:0], in_a};
      b_chain <= {b_chain[SYNC_STAGES-2:0], in_b};
      a_was   <= a_now;
      b_was   <= b_now;
    end
  end

  assign a_now  = a_chain[LAST];
  assign b_now  = b_chain[LAST];
  assign a_rise = a_now & ~a_was;
  assign b_rise = b_now & ~b_was;

  always_comb begin
    order_next = order_code;
    if (!a_now && !b_now)
      order_next = 2'b00;
    else if (b_rise && !a_rise && a_now)
      order_next = 2'b01;
    else if (a_rise && !b_rise && b_now)
      order_next = 2'b10;
  end

  always_ff @(posedge clk) begin
    if (rst) order_code <= 2'b00;
    else     order_code <= order_next;
  end
endmodule

// File: rtl/edge_order_ind_chk.sv
module edge_order_ind_chk (
  input logic       clk,
  input logic       rst,
  input logic       a_now,
  input logic       b_now,
  input logic       a_was,
  input logic       b_was,
  input logic [1:0] order_code
);
  // R2
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_now && !b_now) |=> order_code == 2'b00);

  // R3
  b_last_chk: assert property (@(posedge clk) disable iff (rst)
    (a_now && a_was && b_now && !b_was) |=> order_code == 2'b01);

  // R4
  a_last_chk: assert property (@(posedge clk) disable iff (rst)
    (b_now && b_was && a_now && !a_was) |=> order_code == 2'b10);

  // R6
  tie_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (a_now && !a_was && b_now && !b_was) |=> $stable(order_code));

  // R5
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((a_now == a_was) && (b_now == b_was) && (a_now || b_now)) |=> $stable(order_code));

  // R5
  fall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((!a_now && a_was && b_now && b_was) || (!b_now && b_was && a_now && a_was))
      |=> $stable(order_code));

  // R5
  no_both_chk: assert property (@(posedge clk) disable iff (rst)
    order_code != 2'b11);
endmodule

bind edge_order_ind edge_order_ind_chk u_chk (
  .clk(clk), .rst(rst),
  .a_now(a_now), .b_now(b_now), .a_was(a_was), .b_was(b_was),
  .order_code(order_code)
);

// File: tb/tb_edge_order_ind.sv
`timescale 1ns/1ps
module tb_edge_order_ind;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_a = 1'b0;
  logic in_b = 1'b0;
  logic [1:0] code2, code3;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  edge_order_ind #(.SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .order_code(code2));
  edge_order_ind #(.SYNC_STAGES(3)) dut_deep (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .order_code(code3));

  task automatic check_one(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_both(input string req, input logic [1:0] exp);
    check_one(req, code2, exp);
    check_one(req, code3, exp);
  endtask

  task automatic drive(input logic a, input logic b);
    @(negedge clk);
    in_a = a;
    in_b = b;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_both("R1 reset", 2'b00);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_both("R1 after release", 2'b00);
  endtask

  task automatic t_b_last();
    drive(1, 0); check_both("R8 A alone", 2'b00);
    drive(1, 1); check_both("R3 B after A", 2'b01);
  endtask

  task automatic t_falling();
    drive(0, 1); check_both("R5 A falls", 2'b01);
    drive(1, 1); check_both("R4 A after B", 2'b10);
    drive(1, 0); check_both("R5 B falls", 2'b10);
  endtask

  task automatic t_clear();
    drive(0, 0); check_both("R2 clear from 10", 2'b00);
    drive(0, 1); check_both("R8 B alone", 2'b00);
    drive(1, 1); check_both("R4 A after B", 2'b10);
    drive(0, 1); drive(0, 0); check_both("R2 clear via fall", 2'b00);
    drive(1, 0); drive(1, 1); check_both("R3 again", 2'b01);
    drive(0, 0); check_both("R2 clear from 01", 2'b00);
  endtask

  task automatic t_tie();
    drive(1, 1); check_both("R6 same-sample rise", 2'b00);
    drive(0, 1); check_both("R6 then A falls", 2'b00);
    drive(1, 1); check_both("R4 after tie", 2'b10);
    drive(0, 0);
  endtask

  task automatic t_latency();
    drive(1, 0);
    @(negedge clk);
    in_b = 1'b1;
    repeat (2) @(negedge clk);
    check_one("R7 two-stage before", code2, 2'b00);
    @(negedge clk);
    check_one("R7 two-stage at edge 3", code2, 2'b01);
    check_one("R7 three-stage before", code3, 2'b00);
    @(negedge clk);
    check_one("R7 three-stage at edge 4", code3, 2'b01);
  endtask

  task automatic t_mid_reset();
    drive(0, 1); drive(1, 1);
    check_both("R4 before reset", 2'b10);
    rst = 1'b1;
    @(negedge clk);
    check_both("R1 mid reset", 2'b00);
    rst = 1'b0;
    in_a = 1'b0;
    in_b = 1'b0;
    repeat (6) @(negedge clk);
    check_both("R1 after mid reset", 2'b00);
  endtask

  initial begin
    t_reset();
    t_b_last();
    t_falling();
    t_clear();
    t_tie();
    t_latency();
    t_mid_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule